// File: doc/BRIEF.md
# Thermostat Configuration and Alarm Register

This block keeps the state a small digital thermostat needs around its temperature sensor: an upper limit, a lower limit, and one configuration/status byte. Every finished conversion result arrives on a valid/ready stream. The block compares the signed result with both limits. It updates two live thermostat outputs, and it sets two sticky alarm flags that keep a record of any excursion since reset.

A host writes the limits and the writable bits of the byte through a simple write port, and it reads all three registers at any time. The limits and the two mode bits stand in for nonvolatile cells. A write that changes any of them raises a busy bit for a fixed window that models the cell programming time. Host writes that arrive during that window are dropped. The stream input never stalls: `conv_ready` is held high, so a result is taken in every cycle in which `conv_valid` is high, and a source never needs to wait.

Top module: `thermo_status_reg`

## Requirements
- R1: `cfg_byte` bit 7 is DONE, bit 6 the high flag, bit 5 the low flag, bit 4 the busy bit, bit 3 a constant 1, bit 2 a constant 0, bit 1 the host-mode bit and bit 0 the single-conversion bit. After reset it reads 8'h88, the upper limit reads the most positive value and the lower limit the most negative value.
- R2: A `conv_start` pulse without a result makes DONE read 0 from the next cycle on. An accepted result makes DONE read 1 from the next cycle on.
- R3: The high flag becomes 1 in the cycle after an accepted result that is greater than or equal to the upper limit, compared as signed two's complement.
- R4: The low flag becomes 1 in the cycle after an accepted result that is less than or equal to the lower limit, compared as signed two's complement.
- R5: Once set, a flag stays 1 until an accepted byte write carries 0 in that flag's bit position. Writing 1 there has no effect. When a setting result and a clearing write fall in the same cycle, the flag ends up set.
- R6: Bits 1 and 0 are read/write and reset to 0. Writes have no effect on bits 7, 4, 3 and 2.
- R7: An accepted limit write (`wr_sel` 1 = upper, 2 = lower), or an accepted byte write (`wr_sel` 0) that changes bits 1:0, makes the busy bit read 1 for exactly CLK_KHZ*NV_WRITE_MS cycles, starting the cycle after the write.
- R8: Any write presented while the busy bit is 1 is ignored, and all registers keep their values.
- R9: `t_high` and `t_low` take the values (result >= upper) and (result <= lower) after each accepted result, and hold between results.
- R10: `conv_ready` is always 1. A result transfers on every cycle with `conv_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_start | input | 1 | A conversion has begun |
| conv_valid | input | 1 | Conversion result valid |
| conv_ready | output | 1 | Result accepted (always 1) |
| conv_temp | input | TW | Signed conversion result |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | 0 byte, 1 upper limit, 2 lower limit, 3 none |
| wr_data | input | 8 | Write data; limits use bits TW-1:0 |
| cfg_byte | output | 8 | Configuration/status byte |
| th_out | output | TW | Upper limit |
| tl_out | output | TW | Lower limit |
| t_high | output | 1 | Last result at or above upper limit |
| t_low | output | 1 | Last result at or below lower limit |

## Verification
The assertions assume that `conv_start` and `conv_valid` are never raised together, and that `wr_sel` values are steady whenever `wr_en` is high. The stimulus drives all inputs on the falling edge, one operation at a time. The only exception is a single deliberate collision of a result with a flag-clearing write. Limit writes during the sweep are always followed by a full busy window, so that no limit write is dropped by accident.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
  typedef enum logic [1:0] {
    SEL_CFG  = 2'd0,
    SEL_HI   = 2'd1,
    SEL_LO   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int B_DONE   = 7;
  localparam int B_HIF    = 6;
  localparam int B_LOF    = 5;
  localparam int B_BUSY   = 4;
  localparam int B_ONE    = 3;
  localparam int B_ZERO   = 2;
  localparam int B_HOST   = 1;
  localparam int B_SINGLE = 0;
endpackage

// File: rtl/limit_cmp.sv
module limit_cmp #(
  parameter int TW = 8
) (
  input  logic [TW-1:0] temp,
  input  logic [TW-1:0] hi_lim,
  input  logic [TW-1:0] lo_lim,
  output logic          at_or_above,
  output logic          at_or_below
);
  always_comb begin
    at_or_above = $signed(temp) >= $signed(hi_lim);
    at_or_below = $signed(temp) <= $signed(lo_lim);
  end
endmodule

// File: rtl/sticky_flag.sv
module sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= set | (q & ~clr);
  end
endmodule

// File: rtl/nv_busy_timer.sv
module nv_busy_timer #(
  parameter int BUSY_CYCLES = 10000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(BUSY_CYCLES);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)               remain <= '0;
    else if (start)           remain <= LOAD;
    else if (remain != '0)    remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
endmodule

// File: rtl/thermo_status_reg.sv
module thermo_status_reg
  import thermo_pkg::*;
#(
  parameter int TW          = 8,
  parameter int CLK_KHZ     = 1000,
  parameter int NV_WRITE_MS = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          conv_start,
  input  logic          conv_valid,
  output logic          conv_ready,
  input  logic [TW-1:0] conv_temp,
  input  logic          wr_en,
  input  logic [1:0]    wr_sel,
  input  logic [7:0]    wr_data,
  output logic [7:0]    cfg_byte,
  output logic [TW-1:0] th_out,
  output logic [TW-1:0] tl_out,
  output logic          t_high,
  output logic          t_low
);
  localparam int BUSY_CYCLES = CLK_KHZ * NV_WRITE_MS;
  localparam logic [TW-1:0] HI_RST = {1'b0, {(TW-1){1'b1}}};
  localparam logic [TW-1:0] LO_RST = {1'b1, {(TW-1){1'b0}}};
  localparam int NFLAG = 2;

  reg_sel_e    sel;
  logic        busy, wr_ok, cfg_wr, hi_wr, lo_wr, mode_chg, nv_start;
  logic        conv_fire, done_q, host_q, single_q;
  logic        ge_hi, le_lo;
  logic [NFLAG-1:0] flag_set, flag_clr, flag_q;

  assign sel        = reg_sel_e'(wr_sel);
  assign conv_ready = 1'b1;
  assign conv_fire  = conv_valid & conv_ready;
  assign wr_ok      = wr_en & ~busy;
  assign cfg_wr     = wr_ok && (sel == SEL_CFG);
  assign hi_wr      = wr_ok && (sel == SEL_HI);
  assign lo_wr      = wr_ok && (sel == SEL_LO);
  assign mode_chg   = cfg_wr && (wr_data[B_HOST:B_SINGLE] != {host_q, single_q});
  assign nv_start   = hi_wr | lo_wr | mode_chg;

  limit_cmp #(.TW(TW)) u_cmp (
    .temp(conv_temp), .hi_lim(th_out), .lo_lim(tl_out),
    .at_or_above(ge_hi), .at_or_below(le_lo)
  );

  nv_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst_n(rst_n), .start(nv_start), .busy(busy)
  );

  assign flag_set = {conv_fire & ge_hi, conv_fire & le_lo};
  assign flag_clr = {cfg_wr & ~wr_data[B_HIF], cfg_wr & ~wr_data[B_LOF]};

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    sticky_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .set(flag_set[g]), .clr(flag_clr[g]), .q(flag_q[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q   <= 1'b1;
      host_q   <= 1'b0;
      single_q <= 1'b0;
      th_out   <= HI_RST;
      tl_out   <= LO_RST;
      t_high   <= 1'b0;
      t_low    <= 1'b0;
    end else begin
      if (conv_fire) begin
        done_q <= 1'b1;
        t_high <= ge_hi;
        t_low  <= le_lo;
      end else if (conv_start) begin
        done_q <= 1'b0;
      end
      if (cfg_wr) begin
        host_q   <= wr_data[B_HOST];
        single_q <= wr_data[B_SINGLE];
      end
      if (hi_wr) th_out <= wr_data[TW-1:0];
      if (lo_wr) tl_out <= wr_data[TW-1:0];
    end
  end

  always_comb begin
    cfg_byte           = '0;
    cfg_byte[B_DONE]   = done_q;
    cfg_byte[B_HIF]    = flag_q[1];
    cfg_byte[B_LOF]    = flag_q[0];
    cfg_byte[B_BUSY]   = busy;
    cfg_byte[B_ONE]    = 1'b1;
    cfg_byte[B_ZERO]   = 1'b0;
    cfg_byte[B_HOST]   = host_q;
    cfg_byte[B_SINGLE] = single_q;
  end
endmodule

// File: rtl/thermo_status_chk.sv
module thermo_status_chk #(
  parameter int TW          = 8,
  parameter int CLK_KHZ     = 1000,
  parameter int NV_WRITE_MS = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          conv_start,
  input logic          conv_valid,
  input logic          conv_ready,
  input logic [TW-1:0] conv_temp,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [7:0]    wr_data,
  input logic [7:0]    cfg_byte,
  input logic [TW-1:0] th_out,
  input logic [TW-1:0] tl_out,
  input logic          t_high,
  input logic          t_low
);
  localparam int BUSY_CYCLES = CLK_KHZ * NV_WRITE_MS;

  int busy_run;
  always_ff @(posedge clk) begin
    if (!rst_n)           busy_run <= 0;
    else if (cfg_byte[4]) busy_run <= busy_run + 1;
    else                  busy_run <= 0;
  end

  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    busy_run <= BUSY_CYCLES); // R7

  AST_HI_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && conv_ready && ($signed(conv_temp) >= $signed(th_out))) |=> cfg_byte[6]); // R3

  AST_LO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_valid && conv_ready && ($signed(conv_temp) <= $signed(tl_out))) |=> cfg_byte[5]); // R4

  AST_HI_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_byte[6] && !(wr_en && !cfg_byte[4] && wr_sel == 2'd0 && !wr_data[6])) |=> cfg_byte[6]); // R5

  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !conv_valid) |=> !cfg_byte[7]); // R2

  AST_BUSY_LIMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cfg_byte[4]) |=> ($stable(th_out) && $stable(tl_out) && $stable(cfg_byte[1:0]))); // R8

  AST_OUTPUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_valid |=> ($stable(t_high) && $stable(t_low))); // R9
endmodule

bind thermo_status_reg thermo_status_chk #(
  .TW(TW), .CLK_KHZ(CLK_KHZ), .NV_WRITE_MS(NV_WRITE_MS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_valid(conv_valid),
  .conv_ready(conv_ready), .conv_temp(conv_temp), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .cfg_byte(cfg_byte), .th_out(th_out), .tl_out(tl_out),
  .t_high(t_high), .t_low(t_low)
);

// File: tb/sim_thermo_status_reg.sv
module sim_thermo_status_reg;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 4;
  localparam int NBUSY = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic conv_start = 0, conv_valid = 0, wr_en = 0;
  logic [TW-1:0] conv_temp = '0;
  logic [1:0] wr_sel = 2'd3;
  logic [7:0] wr_data = '0;
  logic conv_ready, t_high, t_low;
  logic [7:0] cfg_byte;
  logic [TW-1:0] th_out, tl_out;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermo_status_reg #(.TW(TW), .CLK_KHZ(1), .NV_WRITE_MS(NBUSY)) u0 (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_valid(conv_valid),
    .conv_ready(conv_ready), .conv_temp(conv_temp), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .cfg_byte(cfg_byte), .th_out(th_out), .tl_out(tl_out),
    .t_high(t_high), .t_low(t_low)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0; wr_sel = 2'd3;
  endtask

  task automatic conv(int t);
    @(negedge clk); conv_valid = 1; conv_temp = TW'(t);
    @(negedge clk); conv_valid = 0;
  endtask

  function automatic logic [7:0] exp_cfg(logic d, logic h, logic l, logic b, logic [1:0] m);
    return {d, h, l, b, 1'b1, 1'b0, m};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset byte", cfg_byte, 8'h88);
    check("R1 reset upper", th_out, 4'h7);
    check("R1 reset lower", tl_out, 4'h8);
    check("R10 ready", conv_ready, 1);
    check("R9 reset outputs", {t_high, t_low}, 2'b00);

    @(negedge clk); conv_start = 1;
    @(negedge clk); conv_start = 0;
    check("R2 done low", cfg_byte[7], 0);
    conv(0);
    check("R2 done high", cfg_byte, 8'h88);
    conv(7);
    check("R3 high flag", cfg_byte, 8'hC8);
    check("R9 t_high set", t_high, 1);
    conv(0);
    check("R5 high sticky", cfg_byte, 8'hC8);
    check("R9 t_high follows", t_high, 0);
    wr(2'd0, 8'h60);
    check("R5 write one no effect", cfg_byte, 8'hC8);
    conv(-8);
    check("R4 low flag", cfg_byte, 8'hE8);
    check("R9 t_low set", t_low, 1);
    wr(2'd0, 8'h20);
    check("R5 clear high only", cfg_byte, 8'hA8);
    @(negedge clk); conv_valid = 1; conv_temp = 4'h7; wr_en = 1; wr_sel = 2'd0; wr_data = 8'h00;
    @(negedge clk); conv_valid = 0; wr_en = 0; wr_sel = 2'd3;
    check("R5 set beats clear", cfg_byte, 8'hC8);

    wr(2'd0, 8'b1001_0111);
    check("R6 R7 mode write and busy", cfg_byte, exp_cfg(1, 0, 0, 1, 2'b11));
    repeat (NBUSY - 1) @(negedge clk);
    check("R7 busy last cycle", cfg_byte[4], 1);
    @(negedge clk);
    check("R7 busy ends", cfg_byte[4], 0);
    check("R6 modes kept", cfg_byte, exp_cfg(1, 0, 0, 0, 2'b11));

    wr(2'd0, 8'h00);
    check("R7 busy on mode change", cfg_byte, exp_cfg(1, 0, 0, 1, 2'b00));
    wr(2'd1, 8'h00);
    check("R8 upper kept", th_out, 4'h7);
    wr(2'd0, 8'h03);
    check("R8 modes kept", cfg_byte[1:0], 2'b00);
    repeat (NBUSY) @(negedge clk);
    check("R7 idle again", cfg_byte[4], 0);

    for (int th = -8; th < 8; th++) begin
      for (int tl = -8; tl < 8; tl++) begin
        wr(2'd1, 8'(th)); repeat (NBUSY) @(negedge clk);
        wr(2'd2, 8'(tl)); repeat (NBUSY) @(negedge clk);
        for (int t = -8; t < 8; t++) begin
          wr(2'd0, 8'h00);
          conv(t);
          check("R3 R4 sweep byte", cfg_byte, exp_cfg(1, t >= th, t <= tl, 0, 2'b00));
          check("R9 sweep outputs", {t_high, t_low}, {t >= th, t <= tl});
        end
      end
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule